// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block is the control side of a tapped delay line. It keeps a tap index of `TAP_W` bits (5 by default, so taps 0 to 31). It reports that index both as a binary value and as a one-hot select bus that drives the tap multiplexer. The analog delay element itself is not part of this block. A parameter fixes the operating mode at build time:

- **Fixed** (`TAPMODE_FIXED`): the tap stays at `INIT_TAP`.
- **Stepping** (`TAPMODE_VAR`): the tap moves one position per enabled cycle, and a load strobe returns it to `INIT_TAP`.
- **Direct load** (`TAPMODE_VARLOAD`): a load strobe takes the value on `tap_in`.
- **Staged load** (`TAPMODE_VARPIPE`): a staging register is written from `tap_in` on a write strobe, and the load strobe moves the staged value into the tap.

Staged load lets many controllers be primed one at a time over a shared `tap_in` bus. All of them then switch on a single common load strobe.

Each cycle a decoder turns the control inputs into one action, and the tap register applies it. The actions are:

- `ACT_HOLD`: keep the tap.
- `ACT_UP`: add one, with wrap.
- `ACT_DOWN`: subtract one, with wrap.
- `ACT_LOAD`: take the mode's load source.

Every transition comes from the current tap value, and the new value is visible after the rising edge at which the request was sampled.

Top module: `tap_sel_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `tap_out` equals `INIT_TAP`. The staging register also resets to `INIT_TAP`.
- R2: In the stepping, direct-load and staged-load modes, with `load_strobe` low: `step_en` high and `step_up` high adds one at the next rising edge; `step_en` high and `step_up` low subtracts one; `step_en` low leaves the tap unchanged.
- R3: Stepping up from 31 gives 0, and stepping down from 0 gives 31.
- R4: In stepping mode, `load_strobe` high sets the tap to `INIT_TAP` at the next edge.
- R5: In direct-load mode, `load_strobe` high sets the tap to the `tap_in` value sampled at that edge.
- R6: In staged-load mode, `stage_wr` high captures `tap_in` into the staging register without changing the tap. `load_strobe` high copies the staging register into the tap. When both are high in the same cycle, the tap receives the value staged before that edge. In the other modes `stage_wr` has no effect on the tap.
- R7: A `load_strobe` request takes priority over a simultaneous `step_en` request.
- R8: In fixed mode, `tap_out` stays at `INIT_TAP` whatever the control inputs do.
- R9: `tap_onehot` has exactly one bit set, and that bit is the one at index `tap_out`.
- R10: With `load_strobe` and `step_en` both low, the tap holds its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Enables one step of the tap this cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| load_strobe | input | 1 | Load the tap from the mode's load source |
| stage_wr | input | 1 | Write `tap_in` into the staging register |
| tap_in | input | TAP_W | Tap value to load or stage |
| tap_out | output | TAP_W | Current tap index |
| tap_onehot | output | 2**TAP_W | One-hot tap select, bit `tap_out` set |

## Verification
The bench drives all four modes from a shared stimulus and compares each against a behavioural model.

- **Wrap:** it steps through both wrap boundaries. A design that saturated would stick at 31 or 0, and one with a wrong width would jump to an unrelated tap.
- **Staging:** it writes the staging register and loads the tap in the same cycle. A design that forwarded the new value would load the wrong tap on that edge.
- **Load priority:** it asserts the load strobe together with a step request. A design without the load priority would move by one instead of loading.
- **Fixed mode:** it keeps checking fixed mode through all of this, which catches any control path that leaks into it.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

    typedef enum logic [1:0] {
        TAPMODE_FIXED   = 2'd0,
        TAPMODE_VAR     = 2'd1,
        TAPMODE_VARLOAD = 2'd2,
        TAPMODE_VARPIPE = 2'd3
    } tap_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2,
        ACT_LOAD = 2'd3
    } tap_act_e;

endpackage

// File: rtl/tapctl_decode.sv
module tapctl_decode
    import tapctl_pkg::*;
#(
    parameter tap_mode_e MODE = TAPMODE_VARPIPE
) (
    input  logic     step_en,
    input  logic     step_up,
    input  logic     load_strobe,
    output tap_act_e act
);

    // load wins over stepping; fixed mode never moves
    always_comb begin
        act = ACT_HOLD;
        unique case (MODE)
            TAPMODE_FIXED: act = ACT_HOLD;
            default: begin
                if (load_strobe)  act = ACT_LOAD;
                else if (step_en) act = step_up ? ACT_UP : ACT_DOWN;
                else              act = ACT_HOLD;
            end
        endcase
    end

endmodule

// File: rtl/tapctl_stage.sv
module tapctl_stage #(
    parameter int                  TAP_W   = 5,
    parameter logic [TAP_W-1:0]    RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [TAP_W-1:0] din,
    output logic [TAP_W-1:0] dout
);

    logic [TAP_W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stage_q <= RST_VAL;
        else if (wr) stage_q <= din;
    end

    assign dout = stage_q;

endmodule

// File: rtl/tapctl_onehot.sv
module tapctl_onehot #(
    parameter int TAP_W = 5,
    localparam int NTAPS = 1 << TAP_W
) (
    input  logic [TAP_W-1:0] idx,
    output logic [NTAPS-1:0] sel
);

    for (genvar g = 0; g < NTAPS; g++) begin : g_dec
        assign sel[g] = (idx == TAP_W'(g));
    end

endmodule

// File: rtl/tap_sel_ctrl.sv
module tap_sel_ctrl
    import tapctl_pkg::*;
#(
    parameter tap_mode_e MODE     = TAPMODE_VARPIPE,
    parameter int        TAP_W    = 5,
    parameter int        INIT_TAP = 0,
    localparam int       NTAPS    = 1 << TAP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_up,
    input  logic             load_strobe,
    input  logic             stage_wr,
    input  logic [TAP_W-1:0] tap_in,
    output logic [TAP_W-1:0] tap_out,
    output logic [NTAPS-1:0] tap_onehot
);

    localparam logic [TAP_W-1:0] INIT_V = TAP_W'(INIT_TAP);

    tap_act_e         act;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] tap_d;
    logic [TAP_W-1:0] stage_val;
    logic [TAP_W-1:0] load_val;

    tapctl_decode #(.MODE(MODE)) u_decode (
        .step_en     (step_en),
        .step_up     (step_up),
        .load_strobe (load_strobe),
        .act         (act)
    );

    // staging register exists only in the staged-load variant
    if (MODE == TAPMODE_VARPIPE) begin : g_stage
        tapctl_stage #(.TAP_W(TAP_W), .RST_VAL(INIT_V)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (stage_wr),
            .din   (tap_in),
            .dout  (stage_val)
        );
    end else begin : g_nostage
        assign stage_val = INIT_V;
    end

    // load source per mode
    if (MODE == TAPMODE_VARLOAD) begin : g_ld_direct
        assign load_val = tap_in;
    end else if (MODE == TAPMODE_VARPIPE) begin : g_ld_staged
        assign load_val = stage_val;
    end else begin : g_ld_init
        assign load_val = INIT_V;
    end

    // next-state process
    always_comb begin
        tap_d = tap_q;
        unique case (act)
            ACT_HOLD: tap_d = tap_q;
            ACT_UP:   tap_d = tap_q + 1'b1;
            ACT_DOWN: tap_d = tap_q - 1'b1;
            ACT_LOAD: tap_d = load_val;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q <= INIT_V;
        else        tap_q <= tap_d;
    end

    // outputs
    assign tap_out = tap_q;

    tapctl_onehot #(.TAP_W(TAP_W)) u_onehot (
        .idx (tap_q),
        .sel (tap_onehot)
    );

endmodule

// File: rtl/tapctl_chk.sv
module tapctl_chk
    import tapctl_pkg::*;
#(
    parameter tap_mode_e MODE     = TAPMODE_VARPIPE,
    parameter int        TAP_W    = 5,
    parameter int        INIT_TAP = 0,
    localparam int       NTAPS    = 1 << TAP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             step_up,
    input logic             load_strobe,
    input logic             stage_wr,
    input logic [TAP_W-1:0] tap_in,
    input logic [TAP_W-1:0] tap_out,
    input logic [NTAPS-1:0] tap_onehot
);

    localparam logic [TAP_W-1:0] INIT_V = TAP_W'(INIT_TAP);

    AST_ONEHOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_onehot) == 1) && tap_onehot[tap_out]); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_strobe && !step_en) |=> $stable(tap_out)); // R10

    if (MODE == TAPMODE_FIXED) begin : g_fixed
        AST_FIXED_TAP: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en || load_strobe || stage_wr) |=> (tap_out == INIT_V)); // R8
    end else begin : g_move
        AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_strobe && step_en && step_up) |=>
            (tap_out == TAP_W'($past(tap_out) + 1'b1))); // R3
        AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_strobe && step_en && !step_up) |=>
            (tap_out == TAP_W'($past(tap_out) - 1'b1))); // R2
    end

    if (MODE == TAPMODE_VAR) begin : g_var
        AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
            load_strobe |=> (tap_out == INIT_V)); // R4
    end

    if (MODE == TAPMODE_VARLOAD) begin : g_vld
        AST_LOAD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
            load_strobe |=> (tap_out == $past(tap_in))); // R5
    end

    if (MODE == TAPMODE_VARPIPE) begin : g_vpipe
        AST_STAGE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_wr && !load_strobe && !step_en) |=> $stable(tap_out)); // R6
    end

endmodule

bind tap_sel_ctrl tapctl_chk #(
    .MODE(MODE), .TAP_W(TAP_W), .INIT_TAP(INIT_TAP)
) u_chk (.*);

// File: tb/sim_tap_sel_ctrl.sv
`timescale 1ns/1ps
module sim_tap_sel_ctrl;
    import tapctl_pkg::*;

    localparam int W = 5;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_en = 1'b0, step_up = 1'b0, load_strobe = 1'b0, stage_wr = 1'b0;
    logic [W-1:0] tap_in = '0;

    logic [W-1:0] t0, t1, t2, t3;
    logic [N-1:0] h0, h1, h2, h3;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string cur_req = "R1";

    // mode per DUT: 0 fixed, 1 stepping, 2 direct, 3 staged
    int mode_of [4] = '{3, 1, 2, 0};
    int init_of [4] = '{7, 12, 3, 20};
    int mdl     [4];
    int mstage;

    always #2.5 clk = ~clk;

    tap_sel_ctrl #(.MODE(TAPMODE_VARPIPE), .TAP_W(W), .INIT_TAP(7)) u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
        .load_strobe(load_strobe), .stage_wr(stage_wr), .tap_in(tap_in),
        .tap_out(t0), .tap_onehot(h0));
    tap_sel_ctrl #(.MODE(TAPMODE_VAR), .TAP_W(W), .INIT_TAP(12)) u1 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
        .load_strobe(load_strobe), .stage_wr(stage_wr), .tap_in(tap_in),
        .tap_out(t1), .tap_onehot(h1));
    tap_sel_ctrl #(.MODE(TAPMODE_VARLOAD), .TAP_W(W), .INIT_TAP(3)) u2 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
        .load_strobe(load_strobe), .stage_wr(stage_wr), .tap_in(tap_in),
        .tap_out(t2), .tap_onehot(h2));
    tap_sel_ctrl #(.MODE(TAPMODE_FIXED), .TAP_W(W), .INIT_TAP(20)) u3 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_up(step_up),
        .load_strobe(load_strobe), .stage_wr(stage_wr), .tap_in(tap_in),
        .tap_out(t3), .tap_onehot(h3));

    function automatic int next_tap(int mode, int cur, int init, int stg,
                                    logic ce, logic inc, logic ld, int tin);
        if (mode == 0) return init;                 // R8
        if (ld) begin                               // R7
            if (mode == 1) return init;             // R4
            if (mode == 2) return tin;              // R5
            return stg;                             // R6
        end
        if (ce) return inc ? (cur + 1) % N : (cur + N - 1) % N; // R2 R3
        return cur;                                 // R10
    endfunction

    task automatic check_one(string dn, int act_t, int exp_t, logic [N-1:0] act_h);
        logic [N-1:0] exp_h;
        exp_h = N'(1) << exp_t;
        vectors++;
        if (act_t != exp_t) begin
            errors++;
            $display("FAIL %s %s tap_out actual %0d expected %0d", cur_req, dn, act_t, exp_t);
        end
        vectors++;
        if (act_h != exp_h) begin                   // R9
            errors++;
            $display("FAIL %s/R9 %s tap_onehot actual %h expected %h", cur_req, dn, act_h, exp_h);
        end
    endtask

    task automatic compare_all();
        check_one("u0", int'(t0), mdl[0], h0);
        check_one("u1", int'(t1), mdl[1], h1);
        check_one("u2", int'(t2), mdl[2], h2);
        check_one("u3", int'(t3), mdl[3], h3);
    endtask

    task automatic cyc(input logic ce, input logic inc, input logic ld,
                       input logic pw, input int v);
        step_en = ce; step_up = inc; load_strobe = ld; stage_wr = pw; tap_in = W'(v);
        @(posedge clk);
        for (int k = 0; k < 4; k++)
            mdl[k] = next_tap(mode_of[k], mdl[k], init_of[k], mstage, ce, inc, ld, v);
        if (pw) mstage = v;
        @(negedge clk);
        compare_all();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            report();
        end
    end

    initial begin
        logic [7:0] lfsr;
        for (int k = 0; k < 4; k++) mdl[k] = init_of[k];
        mstage = 7;
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        // R1: staging reset value reaches tap on first load
        cur_req = "R1";
        cyc(0, 0, 1, 0, 30);
        // R10: idle hold
        cur_req = "R10";
        repeat (6) cyc(0, 1, 0, 0, 5);
        // R2: steps and disabled steps
        cur_req = "R2";
        repeat (4) cyc(1, 1, 0, 0, 0);
        repeat (2) cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        // R3: wrap upward at 31
        cur_req = "R3";
        cyc(0, 0, 0, 1, 31);
        cyc(0, 0, 1, 0, 31);
        repeat (2) cyc(1, 1, 0, 0, 0);
        // R3: wrap downward at 0
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 1, 0, 0);
        repeat (2) cyc(1, 0, 0, 0, 0);
        // R6: staging alone does not move tap; staged vs direct value
        cur_req = "R6";
        cyc(0, 0, 0, 1, 9);
        cyc(0, 0, 0, 0, 25);
        cyc(0, 0, 1, 0, 25);
        cyc(0, 0, 1, 1, 14);
        cyc(0, 0, 1, 0, 2);
        // R7: load wins over step
        cur_req = "R7";
        cyc(1, 1, 1, 0, 17);
        cyc(1, 0, 1, 0, 29);
        // R4: stepping mode load returns to initial
        cur_req = "R4";
        repeat (3) cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 8);
        // R5: direct load
        cur_req = "R5";
        cyc(0, 0, 1, 0, 22);
        cyc(0, 0, 1, 0, 1);
        // R8: fixed mode under mixed pseudo-random activity
        cur_req = "R8";
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cyc(lfsr[0], lfsr[1], lfsr[2] & lfsr[5], lfsr[3], int'(lfsr[7:3]));
        end
        done = 1;
        report();
    end

endmodule